// File: doc/BRIEF.md
# SPI FIFO Threshold Interrupt Controller

This block is the status and interrupt layer between a SPI controller's data FIFOs and its host register port. The host writes transmit words into a transmit FIFO and reads received words out of a receive FIFO through a single data register. The serial shift engine, which is not part of this block, takes words through a pop strobe and delivers words through a push strobe. The host can read both fill levels. It programs a transmit threshold and a receive threshold, each only as wide as the FIFO depth needs.

Five interrupt sources are derived from the FIFOs. Two are live level comparisons: transmit-empty and receive-full. Three are sticky error flags: transmit overflow, receive underflow and receive overflow. Every source has a raw status bit, a mask bit and a masked status bit. The masked bits are ORed into one interrupt line. Clearing the enable bit flushes both FIFOs and the error flags. Software can find the FIFO depth by writing rising threshold values and checking when the readback stops matching.

Top module: `spi_fifo_irq_ctrl`

## Requirements
- R1: After a synchronous reset both levels read 0, both thresholds read 0, the mask reads 0, the enable bit reads 0, `irq` is low, and the raw status reads 5'b00001.
- R2: Register addresses: 0 control, 1 data, 2 transmit threshold, 3 receive threshold, 4 transmit level, 5 receive level, 6 mask, 7 raw status, 8 masked status, 9 flag clear. A data write while enabled appends the low DATA_W bits to the transmit FIFO. `tx_valid`/`tx_data` present the oldest word, and `tx_pop` removes it. Unmapped addresses read 0.
- R3: While enabled, `rx_push` stores `rx_data` in the receive FIFO. A data read returns the oldest stored word, zero-extended, and removes it.
- R4: Status bit 0 (transmit-empty) is 1 in every cycle in which the transmit level is at or below the transmit threshold. It is not sticky.
- R5: Status bit 4 (receive-full) is 1 in every cycle in which the receive level is above the receive threshold, so a threshold of N-1 sets it at N entries. It is not sticky.
- R6: A data write in a cycle that starts with the transmit FIFO full sets sticky bit 1 (transmit overflow). The word is discarded, and a `tx_pop` in that same cycle still removes one word.
- R7: A data read in a cycle that starts with the receive FIFO empty sets sticky bit 2 (receive underflow) and returns 0.
- R8: An `rx_push` in a cycle that starts with the receive FIFO full sets sticky bit 3 (receive overflow), and the sample is discarded.
- R9: A threshold write stores the value only if it is below DEPTH. Otherwise the register keeps its old value.
- R10: Mask bit i set to 1 enables source i. Masked status is raw status AND mask, and `irq` is the OR of the masked status bits.
- R11: A read of address 9 returns the sticky flags in their status positions (bits 1 to 3) and clears them. An error event in the same cycle is kept set.
- R12: Control bit 0 is the enable. In a cycle that starts with it at 0, both FIFOs are emptied, the sticky flags are cleared, and data writes and `rx_push` are ignored. Threshold and mask writes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effects on data and clear addresses) |
| host_addr | input | 4 | Register address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, combinational on `host_addr` |
| tx_data | output | DATA_W | Oldest transmit word (0 when empty) |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_pop | input | 1 | Shift engine takes the oldest transmit word |
| rx_data | input | DATA_W | Word from the shift engine |
| rx_push | input | 1 | Shift engine delivers `rx_data` |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench goes after the exact full and empty boundaries. Suppose a design tested the level after a same-cycle pop instead of at the start of the cycle. It would accept a write into a full FIFO that is being drained and miss the overflow flag. The threshold edges are checked from both sides, so an off-by-one comparison shows up as a receive-full bit that is late or early by one entry. Threshold writes of exactly DEPTH and larger values must leave the register unchanged; a design that truncated the value instead of refusing it would read back 0. The bench also raises an error event in the same cycle as a clear read, and checks that the flush on disable empties both FIFOs and the flags while the thresholds and mask stay writable.

// File: rtl/spi_fic_pkg.sv
package spi_fic_pkg;

    localparam int HOST_W = 32;
    localparam int ADDR_W = 4;
    localparam int SRC_N  = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 4'd0,
        A_DATA  = 4'd1,
        A_TXTHR = 4'd2,
        A_RXTHR = 4'd3,
        A_TXLVL = 4'd4,
        A_RXLVL = 4'd5,
        A_MASK  = 4'd6,
        A_RAW   = 4'd7,
        A_MSTAT = 4'd8,
        A_CLEAR = 4'd9
    } fic_addr_e;

    // error events / sticky flags
    typedef struct packed {
        logic rx_ovf;
        logic rx_udf;
        logic tx_ovf;
    } fic_evt_t;

    // full source vector, bit 0 = tx_empty ... bit 4 = rx_full
    typedef struct packed {
        logic rx_full;
        logic rx_ovf;
        logic rx_udf;
        logic tx_ovf;
        logic tx_empty;
    } fic_src_t;

    function automatic fic_src_t make_src(input logic txe, input fic_evt_t stk,
                                          input logic rxf);
        fic_src_t s;
        s.tx_empty = txe;
        s.tx_ovf   = stk.tx_ovf;
        s.rx_udf   = stk.rx_udf;
        s.rx_ovf   = stk.rx_ovf;
        s.rx_full  = rxf;
        return s;
    endfunction

endpackage

// File: rtl/fic_fifo.sv
module fic_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rp, wp;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush && !rst) begin
            mem[wp] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rp    <= '0;
            wp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R6/R8: level never exceeds the depth
    p_level_bound_r6: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    // R6/R8: a push into a full FIFO with no pop leaves the level unchanged
    p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> (level == $past(level)));

    // R7: a pop from an empty FIFO with no push keeps it empty
    p_empty_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push && !flush) |=> (level == '0));

endmodule

// File: rtl/fic_thresh_reg.sv
module fic_thresh_reg
    import spi_fic_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int THR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [HOST_W-1:0] wdata,
    output logic [THR_W-1:0]  thr
);

    logic in_range;
    assign in_range = (wdata < HOST_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            thr <= '0;
        end else if (wr && in_range) begin
            thr <= wdata[THR_W-1:0];
        end
    end

    // R9: an out-of-range write does not change the stored threshold
    p_thr_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (wr && !in_range) |=> (thr == $past(thr)));

endmodule

// File: rtl/fic_irq_unit.sv
module fic_irq_unit
    import spi_fic_pkg::*;
#(
    parameter int LVL_W = 4,
    parameter int THR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             clr,
    input  fic_evt_t         evt,
    input  logic [LVL_W-1:0] tx_lvl,
    input  logic [LVL_W-1:0] rx_lvl,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    input  logic             mask_wr,
    input  logic [SRC_N-1:0] mask_wdata,
    output fic_src_t         raw,
    output logic [SRC_N-1:0] masked,
    output logic [SRC_N-1:0] mask,
    output logic             irq
);

    fic_evt_t stk;
    logic     txe, rxf;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            stk <= '0;
        end else begin
            stk <= fic_evt_t'((clr ? '0 : stk) | evt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (mask_wr) begin
            mask <= mask_wdata;
        end
    end

    assign txe    = (tx_lvl <= LVL_W'(tx_thr));
    assign rxf    = (rx_lvl > LVL_W'(rx_thr));
    assign raw    = make_src(txe, stk, rxf);
    assign masked = raw & mask;
    assign irq    = |masked;

    // R11: sticky flags never drop without a clear or a flush
    p_sticky_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!clr && !flush) |=> ((stk & $past(stk)) == $past(stk)));

    // R8: a receive overflow event is reported in the next cycle
    p_rxo_set_r8: assert property (@(posedge clk) disable iff (rst)
        (evt.rx_ovf && !flush) |=> raw.rx_ovf);

    // R10: with every source masked the line stays low
    p_mask_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);

endmodule

// File: rtl/spi_fifo_irq_ctrl.sv
module spi_fifo_irq_ctrl
    import spi_fic_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_pop,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_push,
    output logic              irq
);

    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int THR_W = $clog2(DEPTH);

    logic              en_q, flush;
    logic              wr_data, rd_data, rd_clr;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [LVL_W-1:0]  tx_lvl, rx_lvl;
    logic [THR_W-1:0]  tx_thr, rx_thr;
    logic [DATA_W-1:0] tx_head, rx_head;
    logic [SRC_N-1:0]  masked, mask;
    fic_src_t          raw;
    fic_evt_t          evt;

    assign flush   = !en_q;
    assign wr_data = host_wr && (host_addr == A_DATA);
    assign rd_data = host_rd && (host_addr == A_DATA);
    assign rd_clr  = host_rd && (host_addr == A_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (host_wr && (host_addr == A_CTRL)) begin
            en_q <= host_wdata[0];
        end
    end

    assign evt.tx_ovf = en_q && wr_data && tx_full;
    assign evt.rx_udf = en_q && rd_data && rx_empty;
    assign evt.rx_ovf = en_q && rx_push && rx_full;

    fic_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_txq (
        .clk(clk), .rst(rst), .flush(flush),
        .push(wr_data && en_q), .wdata(host_wdata[DATA_W-1:0]),
        .pop(tx_pop && en_q), .rdata(tx_head),
        .level(tx_lvl), .full(tx_full), .empty(tx_empty)
    );

    fic_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_rxq (
        .clk(clk), .rst(rst), .flush(flush),
        .push(rx_push && en_q), .wdata(rx_data),
        .pop(rd_data && en_q), .rdata(rx_head),
        .level(rx_lvl), .full(rx_full), .empty(rx_empty)
    );

    fic_thresh_reg #(.DEPTH(DEPTH)) u_txthr (
        .clk(clk), .rst(rst),
        .wr(host_wr && (host_addr == A_TXTHR)),
        .wdata(host_wdata), .thr(tx_thr)
    );

    fic_thresh_reg #(.DEPTH(DEPTH)) u_rxthr (
        .clk(clk), .rst(rst),
        .wr(host_wr && (host_addr == A_RXTHR)),
        .wdata(host_wdata), .thr(rx_thr)
    );

    fic_irq_unit #(.LVL_W(LVL_W), .THR_W(THR_W)) u_irq (
        .clk(clk), .rst(rst), .flush(flush), .clr(rd_clr), .evt(evt),
        .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .tx_thr(tx_thr), .rx_thr(rx_thr),
        .mask_wr(host_wr && (host_addr == A_MASK)),
        .mask_wdata(host_wdata[SRC_N-1:0]),
        .raw(raw), .masked(masked), .mask(mask), .irq(irq)
    );

    assign tx_valid = !tx_empty;
    assign tx_data  = tx_empty ? '0 : tx_head;

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            A_CTRL:  host_rdata = HOST_W'(en_q);
            A_DATA:  host_rdata = rx_empty ? '0 : HOST_W'(rx_head);
            A_TXTHR: host_rdata = HOST_W'(tx_thr);
            A_RXTHR: host_rdata = HOST_W'(rx_thr);
            A_TXLVL: host_rdata = HOST_W'(tx_lvl);
            A_RXLVL: host_rdata = HOST_W'(rx_lvl);
            A_MASK:  host_rdata = HOST_W'(mask);
            A_RAW:   host_rdata = HOST_W'(raw);
            A_MSTAT: host_rdata = HOST_W'(masked);
            A_CLEAR: host_rdata = HOST_W'({raw.rx_ovf, raw.rx_udf, raw.tx_ovf, 1'b0});
            default: host_rdata = '0;
        endcase
    end

    // R12: a disabled cycle leaves both FIFOs empty and the flags clear
    p_flush_r12: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> (tx_lvl == '0 && rx_lvl == '0 &&
                   !raw.tx_ovf && !raw.rx_udf && !raw.rx_ovf));

    // R6: a write into a full transmit FIFO raises the overflow flag
    p_txo_set_r6: assert property (@(posedge clk) disable iff (rst)
        (en_q && wr_data && tx_full) |=> raw.tx_ovf);

endmodule

// File: tb/sim_spi_fifo_irq_ctrl.sv
module sim_spi_fifo_irq_ctrl;

    localparam int DEPTH  = 8;
    localparam int DATA_W = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [15:0] tx_data;
    logic        tx_valid;
    logic        tx_pop = 1'b0;
    logic [15:0] rx_data = '0;
    logic        rx_push = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int   txq[$];
    int   rxq[$];
    int   tthr, rthr, mmask;
    bit   m_en, s_txo, s_rxu, s_rxo;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2 clk = ~clk;

    spi_fifo_irq_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_pop(tx_pop),
        .rx_data(rx_data), .rx_push(rx_push), .irq(irq)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_raw();
        logic [4:0] r;
        r[0] = (txq.size() <= tthr);
        r[1] = s_txo;
        r[2] = s_rxu;
        r[3] = s_rxo;
        r[4] = (rxq.size() > rthr);
        return {27'b0, r};
    endfunction

    function automatic logic [31:0] m_rd(input logic [3:0] a);
        case (a)
            4'd0: return {31'b0, m_en};
            4'd1: return (rxq.size() > 0) ? 32'(rxq[0]) : 32'd0;
            4'd2: return 32'(tthr);
            4'd3: return 32'(rthr);
            4'd4: return 32'(txq.size());
            4'd5: return 32'(rxq.size());
            4'd6: return 32'(mmask);
            4'd7: return m_raw();
            4'd8: return m_raw() & 32'(mmask);
            4'd9: return {28'b0, s_rxo, s_rxu, s_txo, 1'b0};
            default: return 32'd0;
        endcase
    endfunction

    task automatic step(input bit wr, input bit rd, input logic [3:0] a,
                        input logic [31:0] wd, input bit tp, input bit rp,
                        input logic [15:0] rdd, input string tag);
        int pre_tx, pre_rx;
        @(negedge clk);
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = wd;
        tx_pop = tp; rx_push = rp; rx_data = rdd;
        #1;
        chk("R10", "irq", {31'b0, irq}, {31'b0, |(m_raw() & 32'(mmask))});
        chk("R2", "tx_valid", {31'b0, tx_valid}, {31'b0, txq.size() > 0});
        if (txq.size() > 0) chk("R2", "tx_data", {16'b0, tx_data}, 32'(txq[0]));
        if (rd) chk(tag, "rdata", host_rdata, m_rd(a));
        @(posedge clk);
        pre_tx = txq.size();
        pre_rx = rxq.size();
        if (!m_en) begin
            txq.delete(); rxq.delete();
            s_txo = 0; s_rxu = 0; s_rxo = 0;
        end else begin
            if (rd && a == 4'd9) begin s_txo = 0; s_rxu = 0; s_rxo = 0; end
            if (tp && pre_tx > 0) void'(txq.pop_front());
            if (wr && a == 4'd1) begin
                if (pre_tx == DEPTH) s_txo = 1;
                else txq.push_back(int'(wd[15:0]));
            end
            if (rp) begin
                if (pre_rx == DEPTH) s_rxo = 1;
                else rxq.push_back(int'(rdd));
            end
            if (rd && a == 4'd1) begin
                if (pre_rx == 0) s_rxu = 1;
                else void'(rxq.pop_front());
            end
        end
        if (wr) begin
            case (a)
                4'd0: m_en = wd[0];
                4'd2: if (wd < DEPTH) tthr = int'(wd);
                4'd3: if (wd < DEPTH) rthr = int'(wd);
                4'd6: mmask = int'(wd[4:0]);
                default: ;
            endcase
        end
    endtask

    task automatic wreg(input logic [3:0] a, input logic [31:0] d, input string tag);
        step(1, 0, a, d, 0, 0, 16'h0, tag);
    endtask

    task automatic rreg(input logic [3:0] a, input string tag);
        step(0, 1, a, 32'h0, 0, 0, 16'h0, tag);
    endtask

    task automatic rxin(input logic [15:0] d, input string tag);
        step(0, 0, 4'd0, 32'h0, 0, 1, d, tag);
    endtask

    task automatic txout(input string tag);
        step(0, 0, 4'd0, 32'h0, 1, 0, 16'h0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL ALL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        txq.delete(); rxq.delete();
        tthr = 0; rthr = 0; mmask = 0; m_en = 0;
        s_txo = 0; s_rxu = 0; s_rxo = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every register
        for (int a = 0; a < 11; a++) rreg(4'(a), "R1");

        wreg(4'd0, 32'd1, "R12");
        wreg(4'd6, 32'h1F, "R10");

        // R4: transmit-empty against threshold 2
        wreg(4'd2, 32'd2, "R4");
        rreg(4'd7, "R4");
        for (int i = 0; i < 3; i++) wreg(4'd1, 32'hA000 + 32'(i), "R2");
        rreg(4'd7, "R4");
        rreg(4'd4, "R2");
        txout("R2");
        rreg(4'd7, "R4");

        // R6: overflow at full, and write+pop while full
        for (int i = 0; i < 6; i++) wreg(4'd1, 32'hB000 + 32'(i), "R6");
        rreg(4'd4, "R6");
        wreg(4'd1, 32'hDEAD, "R6");
        rreg(4'd4, "R6");
        rreg(4'd7, "R6");
        step(1, 0, 4'd1, 32'hBEEF, 1, 0, 16'h0, "R6");
        rreg(4'd4, "R6");

        // R11: clear read returns and clears flags
        rreg(4'd9, "R11");
        rreg(4'd7, "R11");
        for (int i = 0; i < 8; i++) txout("R2");

        // R5: receive-full against threshold 3
        wreg(4'd3, 32'd3, "R5");
        for (int i = 0; i < 3; i++) rxin(16'hC000 + 16'(i), "R3");
        rreg(4'd7, "R5");
        rxin(16'hC003, "R5");
        rreg(4'd7, "R5");
        rreg(4'd1, "R3");
        rreg(4'd1, "R3");
        rreg(4'd5, "R3");

        // R8: receive overflow, then R11 same-cycle set wins
        for (int i = 0; i < 6; i++) rxin(16'hD000 + 16'(i), "R3");
        rxin(16'hEEEE, "R8");
        rreg(4'd7, "R8");
        rreg(4'd5, "R8");
        step(0, 1, 4'd9, 32'h0, 0, 1, 16'hFFFF, "R11");
        rreg(4'd7, "R11");

        // R7: drain then underflow
        for (int i = 0; i < 8; i++) rreg(4'd1, "R3");
        rreg(4'd1, "R7");
        rreg(4'd7, "R7");

        // R9: out-of-range threshold writes
        wreg(4'd2, 32'd8, "R9");
        rreg(4'd2, "R9");
        wreg(4'd2, 32'd7, "R9");
        rreg(4'd2, "R9");
        wreg(4'd3, 32'd255, "R9");
        rreg(4'd3, "R9");

        // R10: mask patterns
        wreg(4'd6, 32'h0, "R10");
        rreg(4'd8, "R10");
        wreg(4'd6, 32'h04, "R10");
        rreg(4'd8, "R10");
        wreg(4'd6, 32'h10, "R10");
        rreg(4'd8, "R10");
        rreg(4'd6, "R10");

        // R12: disable flushes, ignores data, keeps config writable
        for (int i = 0; i < 3; i++) wreg(4'd1, 32'h1100 + 32'(i), "R12");
        rxin(16'h2200, "R12");
        wreg(4'd0, 32'd0, "R12");
        rreg(4'd4, "R12");
        rreg(4'd5, "R12");
        rreg(4'd9, "R12");
        wreg(4'd1, 32'h3300, "R12");
        rxin(16'h4400, "R12");
        rreg(4'd4, "R12");
        rreg(4'd5, "R12");
        wreg(4'd2, 32'd1, "R12");
        rreg(4'd2, "R12");
        wreg(4'd0, 32'd1, "R12");
        rreg(4'd0, "R12");

        // mixed traffic compared against the model every cycle
        wreg(4'd6, 32'h1F, "R10");
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            r = lfsr;
            case (r[3:0])
                4'd0, 4'd1, 4'd2:
                    step(1, 0, 4'd1, {16'h0, r[31:16]}, r[4], r[5], r[23:8], "R2");
                4'd3, 4'd4, 4'd5:
                    step(0, 1, 4'd1, 32'h0, r[4], r[5], r[23:8], "R3");
                4'd6: step(1, 0, 4'd2, {28'h0, r[11:8]}, r[4], r[5], r[23:8], "R9");
                4'd7: step(1, 0, 4'd3, {28'h0, r[11:8]}, r[4], r[5], r[23:8], "R9");
                4'd8: step(1, 0, 4'd6, {27'h0, r[12:8]}, r[4], r[5], r[23:8], "R10");
                4'd9: step(0, 1, 4'd9, 32'h0, r[4], r[5], r[23:8], "R11");
                4'd10: step(1, 0, 4'd0, {31'h0, (r[15:8] != 8'h0)}, r[4], r[5], r[23:8], "R12");
                default:
                    step(0, 1, 4'(r[7:4] % 4'd11), 32'h0, r[8], r[9], r[23:8], "R2");
            endcase
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule